// File: doc/BRIEF.md
# Soft-Error Gate Fault Injector

This block runs a stream of random trials on the Boolean function (a+b)c, which it builds in two equivalent ways. The two-gate form ORs a with b and ANDs the result with c. The three-gate form ANDs each of a and b with c and ORs the two products. On every trial, each of the five gates may complement its output. A gate flips when its own pseudo-random 8-bit sample falls below a programmed threshold, so each gate flips with probability close to threshold/256. Each faulty output is compared against a fault-free evaluation, and the mismatches of each structure are counted.

Software or a test sequencer loads a trial count, a threshold and a seed, then pulses start. One trial completes per clock. A single-cycle done pulse marks the end of the run, and the two saturating counters then show how often each structure gave a wrong answer. All random streams come from the seed, so the same settings always produce the same counts.

Top module: `soft_gate_fault_eval`

## Requirements
- R1: After reset, done is 0 and both error counters are 0.
- R2: With trial count N (N may be 0), done goes high for exactly one cycle, on the (N+1)-th clock edge after the edge that accepts start. After that edge the counters hold their final values. A run with N=0 ends with both counters at 0.
- R3: An accepted start clears both counters. Neither counter ever exceeds the number of trials run so far.
- R4: With threshold 0, no gate flips, and both counters stay at 0 for the whole run.
- R5: A start pulse that arrives while a run is in progress is ignored. The current run keeps its trial count, threshold and done timing.
- R6: Two runs with the same seed, threshold and trial count end with identical counter values.
- R7: Each counter is CNT_W bits wide and saturates at 2^CNT_W−1 without wrapping. A narrower instance therefore reports min(true count, 2^CNT_W−1).
- R8: With a small threshold (32), the three-gate structure shows more errors than the two-gate structure. The two-gate error count lies between 10% and 25% of the trials.
- R9: With threshold 255, almost every gate flips. The two-gate form is then wrong whenever c=0. The three-gate form is wrong only when c=1 and exactly one of a, b is 1. As a result, the two-gate count exceeds the three-gate count.
- R10: While no run is in progress, the counters do not change until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| trials | input | TRIAL_W | Number of trials, captured at start |
| eps | input | 8 | Flip threshold; a gate flips when its sample < eps |
| seed | input | LFSR_W | Seed for all random lanes, captured at start |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_a | output | CNT_W | Mismatch count of the two-gate structure |
| err_b | output | CNT_W | Mismatch count of the three-gate structure |

## Verification
Broken control state shows up at once in done timing. A stuck or wrongly loaded remaining-trial count moves the done pulse away from cycle N+1, or leaves done asserted for two cycles. This is visible from the first run. Faults in the random lanes or the flip comparators show up at the end of a run. They give nonzero counts at threshold 0, lose the ordering between the two structures at threshold 32 or 255, or make repeated runs with the same seed disagree. A narrow second instance exposes counter wrap-around, because its counts must equal the saturated copy of the wide ones.

// File: rtl/soft_gate_fault_eval.sv
module soft_gate_fault_eval #(
  parameter int TRIAL_W = 20,
  parameter int CNT_W   = 16,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] POLY = LFSR_W'(16'hB400)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TRIAL_W-1:0] trials,
  input  logic [7:0]         eps,
  input  logic [LFSR_W-1:0]  seed,
  output logic               done,
  output logic [CNT_W-1:0]   err_a,
  output logic [CNT_W-1:0]   err_b
);
  localparam int GATES = 5;
  localparam int LANES = GATES + 1;
  localparam int IN_LANE = GATES;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [LFSR_W-1:0] lane_seed(input logic [LFSR_W-1:0] s, input int k);
    logic [LFSR_W-1:0] v;
    v = (k == 0) ? s : ((s << (3 * k)) | (s >> (LFSR_W - 3 * k)));
    v = v ^ LFSR_W'(32'h9E37 * (k + 1));
    if (v == '0) v = LFSR_W'(1);
    return v;
  endfunction

  logic [LANES-1:0][LFSR_W-1:0] lfsr;
  logic [GATES-1:0]             flip;
  logic [TRIAL_W-1:0]           remaining, trials_q;
  logic [7:0]                   eps_q;
  logic                         running;

  wire launch = start & ~running;
  wire step   = running & (remaining != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (launch)
          lfsr[k] <= lane_seed(seed, k);
        else if (step)
          lfsr[k] <= (lfsr[k] >> 1) ^ (lfsr[k][0] ? POLY : '0);
      end
    end
  end

  for (genvar g = 0; g < GATES; g++) begin : g_flip
    assign flip[g] = lfsr[g][LFSR_W-1 -: 8] < eps_q;
  end

  wire in_a = lfsr[IN_LANE][0];
  wire in_b = lfsr[IN_LANE][1];
  wire in_c = lfsr[IN_LANE][2];

  wire golden = (in_a | in_b) & in_c;

  wire a_or  = (in_a | in_b) ^ flip[0];
  wire a_out = (a_or & in_c) ^ flip[1];

  wire b_and0 = (in_a & in_c) ^ flip[2];
  wire b_and1 = (in_b & in_c) ^ flip[3];
  wire b_out  = (b_and0 | b_and1) ^ flip[4];

  wire miss_a = a_out ^ golden;
  wire miss_b = b_out ^ golden;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
      trials_q  <= '0;
      eps_q     <= '0;
      err_a     <= '0;
      err_b     <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        running   <= 1'b1;
        remaining <= trials;
        trials_q  <= trials;
        eps_q     <= eps;
        err_a     <= '0;
        err_b     <= '0;
      end else if (running) begin
        if (remaining == '0) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          remaining <= remaining - 1'b1;
          if (miss_a && err_a != CNT_MAX) err_a <= err_a + 1'b1;
          if (miss_b && err_b != CNT_MAX) err_b <= err_b + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && remaining == '0 && !launch) |=> (done && !running));

  assert_err_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (32'(err_a) <= 32'(trials_q) - 32'(remaining)) &&
                (32'(err_b) <= 32'(trials_q) - 32'(remaining)));

  assert_zero_eps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && eps_q == 8'd0) |=> ($stable(err_a) && $stable(err_b)));

  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start) |=> ($stable(trials_q) && $stable(eps_q)));

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_a == CNT_MAX && !launch) |=> (err_a == CNT_MAX));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(err_a) && $stable(err_b)));
endmodule

// File: tb/tb_soft_gate_fault_eval.sv
module tb_soft_gate_fault_eval;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [19:0] trials = '0;
  logic [7:0]  eps = '0;
  logic [15:0] seed = '0;
  logic        done, done_s;
  logic [15:0] err_a, err_b;
  logic [5:0]  err_a_s, err_b_s;

  always #2.5 clk = ~clk;

  soft_gate_fault_eval #(.TRIAL_W(20), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .trials(trials), .eps(eps), .seed(seed),
    .done(done), .err_a(err_a), .err_b(err_b));

  soft_gate_fault_eval #(.TRIAL_W(20), .CNT_W(6)) dut_sat (
    .clk(clk), .rst_n(rst_n), .start(start), .trials(trials), .eps(eps), .seed(seed),
    .done(done_s), .err_a(err_a_s), .err_b(err_b_s));

  typedef struct { int exp_cyc; int n; bit eps0; } item_t;
  item_t q[$];
  int ncyc = 0, nchk = 0, nerr = 0;
  bit prev_done = 1'b0, finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) ncyc++;

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) check(1'b0, "R2 unexpected done", 1, 0);
        else begin
          it = q.pop_front();
          check(ncyc == it.exp_cyc, "R2 done cycle", ncyc, it.exp_cyc);
          check(int'(err_a) <= it.n, "R3 err_a bound", err_a, it.n);
          check(int'(err_b) <= it.n, "R3 err_b bound", err_b, it.n);
          if (it.eps0) check(err_a == 0 && err_b == 0, "R4 zero threshold", err_a + err_b, 0);
        end
      end
      if (done && prev_done) check(1'b0, "R2 done longer than one cycle", 2, 1);
      prev_done = done;
    end
  end

  task automatic launch(input int n, input int e, input int s);
    @(negedge clk);
    trials = 20'(n); eps = 8'(e); seed = 16'(s); start = 1'b1;
    q.push_back('{ncyc + n + 2, n, e == 0});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_sat();
    check(int'(err_a_s) == ((err_a > 63) ? 63 : int'(err_a)), "R7 saturation a", err_a_s, (err_a > 63) ? 63 : err_a);
    check(int'(err_b_s) == ((err_b > 63) ? 63 : int'(err_b)), "R7 saturation b", err_b_s, (err_b > 63) ? 63 : err_b);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : driver
    int a1, b1;
    repeat (3) @(negedge clk);
    check(done == 0 && err_a == 0 && err_b == 0, "R1 reset state", err_a + err_b + done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && err_a == 0 && err_b == 0, "R1 after release", err_a + err_b + done, 0);

    launch(0, 200, 16'h1234); wait_done();
    check(err_a == 0 && err_b == 0, "R2 zero trials", err_a + err_b, 0);

    launch(5, 255, 16'h4321); wait_done();

    launch(12, 64, 16'h0F0F);
    repeat (3) @(negedge clk);
    start = 1'b1; trials = 20'd2; eps = 8'd0;
    @(negedge clk); start = 1'b0;
    wait_done();

    launch(300, 0, 16'hBEEF); wait_done();
    check(err_a == 0 && err_b == 0, "R4 zero errors", err_a + err_b, 0);

    launch(500, 64, 16'hC0DE); wait_done();
    a1 = err_a; b1 = err_b;
    check(a1 > 0, "R3 counts nonzero at threshold 64", a1, 1);
    check_sat();
    repeat (5) @(negedge clk);
    check(int'(err_a) == a1 && int'(err_b) == b1, "R10 idle hold", err_a, a1);
    launch(500, 64, 16'hC0DE); wait_done();
    check(int'(err_a) == a1, "R6 repeat err_a", err_a, a1);
    check(int'(err_b) == b1, "R6 repeat err_b", err_b, b1);

    launch(20000, 32, 16'h2468); wait_done();
    check(err_b > err_a, "R8 three-gate worse", err_b, err_a);
    check(err_a >= 2000 && err_a <= 5000, "R8 two-gate rate", err_a, 3440);
    check_sat();

    launch(4000, 255, 16'h1357); wait_done();
    check(err_a > err_b, "R9 two-gate worse at full flip", err_a, err_b);
    check(err_a_s == 6'd63, "R7 narrow counter saturated", err_a_s, 63);
    check_sat();

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 all runs completed", q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule